// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two direction predictors side by side and lets a trained chooser decide which one to trust for each branch. The per-branch component keeps a table of 2-bit saturating counters addressed by the branch address. The history-based component keeps a second table of 2-bit saturating counters addressed by the outcomes of the most recent branches. A third table, also addressed by the branch address, holds 2-bit saturating chooser counters. Each chooser counter learns which component has recently been right more often for the branches that map to it.

The fetch side presents a branch word address (the PC with its alignment bits already dropped) on the predict port. In the same cycle it receives the final direction and the two component directions. When the branch resolves, the back end presents the same address on the update port, together with the real outcome and the two component directions returned at prediction time. All three tables, and the history register, take the new values at the next clock edge. The block does not buffer or recover history: updates are applied in the order they arrive.

Counters and choosers are each one of four named states. The direction counter states are STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). A taken outcome moves a counter one state toward STRONG_T and a not-taken outcome moves it one state toward STRONG_NT, saturating at both ends. The chooser states are LOCAL_STRONG (00), LOCAL_WEAK (01), GLOBAL_WEAK (10) and GLOBAL_STRONG (11). A "global won" update moves a chooser one state toward GLOBAL_STRONG, a "local won" update moves it one state toward LOCAL_STRONG, and both saturate.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every direction counter is WEAK_NT, every chooser is LOCAL_WEAK and the history is zero. As a result, every address predicts not taken on all three outputs until the first update.
- R2: The local prediction is 1 exactly when the local counter at the address index is WEAK_T or STRONG_T. The index is formed by folding the address: address bit i is XORed into index bit (i mod index width).
- R3: On each update, the local counter at the folded update address steps one state toward the outcome and saturates at STRONG_T and STRONG_NT.
- R4: The global prediction is 1 exactly when the global counter selected by the current history value is WEAK_T or STRONG_T. On update, that same entry (the one selected by the history before the shift) steps toward the outcome with saturation.
- R5: On each update, the history shifts left by one and the outcome enters bit 0 (1 = taken), so bit 0 is always the newest outcome.
- R6: The final prediction equals the global prediction when the chooser at the folded address is GLOBAL_WEAK or GLOBAL_STRONG, and equals the local prediction otherwise.
- R7: When the two component directions supplied with an update are equal, the chooser does not change.
- R8: When the supplied component directions differ, the chooser steps one state toward the component whose direction equals the outcome, saturating at GLOBAL_STRONG and LOCAL_STRONG.
- R9: Both component tables are trained on every update, whichever component the chooser favoured.
- R10: With the update valid low, no table entry and no history bit changes, whatever the other update inputs carry.
- R11: Predictions are combinational from the current state. An update becomes visible on the predict outputs from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Branch word address to predict |
| pred_taken | output | 1 | Final predicted direction (1 = taken) |
| pred_local | output | 1 | Direction from the per-branch table |
| pred_global | output | 1 | Direction from the history-indexed table |
| upd_valid | input | 1 | Apply a resolved branch this cycle |
| upd_pc | input | PC_W | Word address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |
| upd_local | input | 1 | Local direction given when this branch was predicted |
| upd_global | input | 1 | Global direction given when this branch was predicted |

## Verification
The assertions assume that every input carries a known 0 or 1 once reset is released, and that upd_valid is held low while reset is applied. Under those conditions the history and hold checks refer only to states written after reset. The bench drives every input on the falling edge from defined values and keeps upd_valid low throughout reset. It supplies upd_local and upd_global either from the directions its own model produced one cycle earlier for the same address, or, in the random phase, as free bits to reach every chooser transition. The assertions do not rely on those two inputs matching earlier predictions.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    typedef enum logic [1:0] {
        SEL_LOCAL_STRONG  = 2'b00,
        SEL_LOCAL_WEAK    = 2'b01,
        SEL_GLOBAL_WEAK   = 2'b10,
        SEL_GLOBAL_STRONG = 2'b11
    } sel_state_e;

endpackage

// File: rtl/tp_pc_fold.sv
// Folds a word address into a table index: bit i goes to index bit i mod IDX_W.
module tp_pc_fold #(
    parameter int PC_W  = 30,
    parameter int IDX_W = 6
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = 0; i < PC_W; i++) begin
            idx[i % IDX_W] = idx[i % IDX_W] ^ pc[i];
        end
    end

endmodule

// File: rtl/tp_ctr_table.sv
// Table of 2-bit direction counters, one read port and one training port.
module tp_ctr_table
    import tp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int ENTRIES = 1 << IDX_W;

    ctr_state_e tbl_q [ENTRIES];
    ctr_state_e wr_cur;
    ctr_state_e wr_next;
    ctr_state_e rd_state;

    // next state of the entry being trained
    always_comb begin
        wr_cur  = tbl_q[wr_idx];
        wr_next = wr_cur;
        unique case (wr_cur)
            CTR_STRONG_NT: wr_next = wr_taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   wr_next = wr_taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    wr_next = wr_taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  wr_next = wr_taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       wr_next = CTR_WEAK_NT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                tbl_q[e] <= CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            tbl_q[wr_idx] <= wr_next;
        end
    end

    // output decode
    always_comb begin
        rd_state = tbl_q[rd_idx];
        rd_taken = (rd_state == CTR_WEAK_T) || (rd_state == CTR_STRONG_T);
    end

endmodule

// File: rtl/tp_sel_table.sv
// Table of 2-bit chooser counters; a step happens only when the components disagreed.
module tp_sel_table
    import tp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_use_global,
    input  logic             step_en,
    input  logic [IDX_W-1:0] step_idx,
    input  logic             step_to_global
);

    localparam int ENTRIES = 1 << IDX_W;

    sel_state_e sel_q [ENTRIES];
    sel_state_e step_cur;
    sel_state_e step_next;
    sel_state_e rd_state;

    always_comb begin
        step_cur  = sel_q[step_idx];
        step_next = step_cur;
        unique case (step_cur)
            SEL_LOCAL_STRONG:
                step_next = step_to_global ? SEL_LOCAL_WEAK    : SEL_LOCAL_STRONG;
            SEL_LOCAL_WEAK:
                step_next = step_to_global ? SEL_GLOBAL_WEAK   : SEL_LOCAL_STRONG;
            SEL_GLOBAL_WEAK:
                step_next = step_to_global ? SEL_GLOBAL_STRONG : SEL_LOCAL_WEAK;
            SEL_GLOBAL_STRONG:
                step_next = step_to_global ? SEL_GLOBAL_STRONG : SEL_GLOBAL_WEAK;
            default:
                step_next = SEL_LOCAL_WEAK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                sel_q[e] <= SEL_LOCAL_WEAK;
            end
        end else if (step_en) begin
            sel_q[step_idx] <= step_next;
        end
    end

    always_comb begin
        rd_state      = sel_q[rd_idx];
        rd_use_global = (rd_state == SEL_GLOBAL_WEAK) || (rd_state == SEL_GLOBAL_STRONG);
    end

endmodule

// File: rtl/tp_ghist.sv
// Global outcome history; newest outcome in bit 0.
module tp_ghist #(
    parameter int GH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            shift_bit,
    output logic [GH_W-1:0] hist
);

    logic [GH_W-1:0] hist_q;
    logic [GH_W-1:0] hist_d;

    generate
        if (GH_W == 1) begin : g_single
            always_comb hist_d = shift_bit;
        end else begin : g_shift
            always_comb hist_d = {hist_q[GH_W-2:0], shift_bit};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
    parameter int PC_W   = 30,
    parameter int LIDX_W = 6,
    parameter int SIDX_W = 6,
    parameter int GH_W   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_local,
    input  logic            upd_global
);

    logic [LIDX_W-1:0] lrd_idx;
    logic [LIDX_W-1:0] lwr_idx;
    logic [SIDX_W-1:0] srd_idx;
    logic [SIDX_W-1:0] swr_idx;
    logic [GH_W-1:0]   ghist_q;
    logic              use_global;
    logic              sel_step;
    logic              sel_to_global;
    logic              local_dir;
    logic              global_dir;

    tp_pc_fold #(.PC_W(PC_W), .IDX_W(LIDX_W)) u_fold_lrd (.pc(pred_pc), .idx(lrd_idx));
    tp_pc_fold #(.PC_W(PC_W), .IDX_W(LIDX_W)) u_fold_lwr (.pc(upd_pc),  .idx(lwr_idx));
    tp_pc_fold #(.PC_W(PC_W), .IDX_W(SIDX_W)) u_fold_srd (.pc(pred_pc), .idx(srd_idx));
    tp_pc_fold #(.PC_W(PC_W), .IDX_W(SIDX_W)) u_fold_swr (.pc(upd_pc),  .idx(swr_idx));

    // per-branch component
    tp_ctr_table #(.IDX_W(LIDX_W)) u_local (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lrd_idx),
        .rd_taken (local_dir),
        .wr_en    (upd_valid),
        .wr_idx   (lwr_idx),
        .wr_taken (upd_taken)
    );

    // history-indexed component; trained at the pre-shift history
    tp_ctr_table #(.IDX_W(GH_W)) u_global (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ghist_q),
        .rd_taken (global_dir),
        .wr_en    (upd_valid),
        .wr_idx   (ghist_q),
        .wr_taken (upd_taken)
    );

    tp_ghist #(.GH_W(GH_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist      (ghist_q)
    );

    // chooser training: only a disagreement carries information
    always_comb begin
        sel_step      = upd_valid && (upd_local != upd_global);
        sel_to_global = (upd_global == upd_taken);
    end

    tp_sel_table #(.IDX_W(SIDX_W)) u_sel (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_idx         (srd_idx),
        .rd_use_global  (use_global),
        .step_en        (sel_step),
        .step_idx       (swr_idx),
        .step_to_global (sel_to_global)
    );

    always_comb begin
        pred_local  = local_dir;
        pred_global = global_dir;
        pred_taken  = use_global ? global_dir : local_dir;
    end

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int PC_W = 30,
    parameter int GH_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pred_pc,
    input logic            pred_taken,
    input logic            pred_local,
    input logic            pred_global,
    input logic            upd_valid,
    input logic            upd_taken,
    input logic [GH_W-1:0] ghist
);

    // R6: when the components agree the choice cannot matter
    a_r6_agree_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local));

    // R5: newest outcome lands in bit 0
    a_r5_newest_bit: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist[0] == $past(upd_taken)));

    generate
        if (GH_W > 1) begin : g_upper
            // R5: older bits move up by one
            a_r5_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid |=> (ghist[GH_W-1:1] == $past(ghist[GH_W-2:0])));
        end
    endgenerate

    // R10: no update, history held
    a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghist));

    // R10 / R11: no update and same address, all predictions held
    a_r10_pred_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(upd_valid) && $stable(pred_pc)) |->
            ($stable(pred_local) && $stable(pred_global) && $stable(pred_taken)));

endmodule

bind tournament_predictor tp_checker #(.PC_W(PC_W), .GH_W(GH_W)) u_tp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pred_pc     (pred_pc),
    .pred_taken  (pred_taken),
    .pred_local  (pred_local),
    .pred_global (pred_global),
    .upd_valid   (upd_valid),
    .upd_taken   (upd_taken),
    .ghist       (ghist_q)
);

// File: tb/tb_tournament_predictor.sv
`timescale 1ns/1ps
module tb_tournament_predictor;

    localparam int PCW = 30;
    localparam int LW  = 6;
    localparam int SW  = 6;
    localparam int GW  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [PCW-1:0] pred_pc = '0;
    logic           pred_taken, pred_local, pred_global;
    logic           upd_valid = 1'b0;
    logic [PCW-1:0] upd_pc = '0;
    logic           upd_taken = 1'b0;
    logic           upd_local = 1'b0;
    logic           upd_global = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    int lc [1<<LW];
    int gc [1<<GW];
    int sc [1<<SW];
    int gh;
    bit last_l, last_g;

    always #2.5 clk = ~clk;   // 200 MHz

    tournament_predictor #(.PC_W(PCW), .LIDX_W(LW), .SIDX_W(SW), .GH_W(GW)) dut (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_local(upd_local), .upd_global(upd_global)
    );

    function automatic int fold(int pc, int w);
        int r = 0;
        for (int i = 0; i < PCW; i++) begin
            if (((pc >> i) & 1) != 0) r = r ^ (1 << (i % w));
        end
        return r;
    endfunction

    function automatic int sat(int v, bit up);
        if (up) return (v < 3) ? v + 1 : 3;
        return (v > 0) ? v - 1 : 0;
    endfunction

    task automatic chk(string tag, logic act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare before the rising edge
    // (R11: outputs reflect state left by the previous edge), then advance the model.
    task automatic step(int pc, bit uv, int upc, bit ut, bit ul, bit ug, string ph);
        int li, si;
        bit el, eg, ef;
        @(negedge clk);
        pred_pc    = pc[PCW-1:0];
        upd_valid  = uv;
        upd_pc     = upc[PCW-1:0];
        upd_taken  = ut;
        upd_local  = ul;
        upd_global = ug;
        #1;
        li = fold(pc, LW);
        si = fold(pc, SW);
        el = (lc[li] >= 2);
        eg = (gc[gh] >= 2);
        ef = (sc[si] >= 2) ? eg : el;
        last_l = el;
        last_g = eg;
        chk($sformatf("%s R2 local", ph),  pred_local,  el);
        chk($sformatf("%s R4 global", ph), pred_global, eg);
        chk($sformatf("%s R6 final", ph),  pred_taken,  ef);
        @(posedge clk);
        if (uv) begin
            int ui = fold(upc, LW);
            int us = fold(upc, SW);
            lc[ui] = sat(lc[ui], ut);            // R3 R9
            gc[gh] = sat(gc[gh], ut);            // R4 R9
            if (ul != ug) sc[us] = sat(sc[us], ug == ut);  // R7 R8
            gh = ((gh << 1) | int'(ut)) & ((1 << GW) - 1); // R5
        end
    endtask

    // predict a branch, then resolve it on the next cycle with the returned directions
    task automatic branch(int pc, bit outc, string ph);
        bit pl, pg;
        step(pc, 0, 0, 0, 0, 0, ph);
        pl = last_l;
        pg = last_g;
        step(int'($urandom_range(0, 4095)), 1, pc, outc, pl, pg, ph);
    endtask

    initial begin
        for (int i = 0; i < (1<<LW); i++) lc[i] = 1;
        for (int i = 0; i < (1<<GW); i++) gc[i] = 1;
        for (int i = 0; i < (1<<SW); i++) sc[i] = 1;
        gh = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every address predicts not taken
        for (int k = 0; k < 8; k++) step(k * 977 + 3, 0, 0, 0, 0, 0, "R1 reset");

        // R3 R9: loop-style branch, taken seven times then falls through
        for (int rep = 0; rep < 6; rep++)
            for (int k = 0; k < 8; k++) branch(40, k != 7, "R3 R9 loop");

        // R5 R8: alternating branch, history makes the global side win
        for (int k = 0; k < 40; k++) branch(1234, k[0], "R5 R8 alternating");

        // R10: update inputs busy but invalid
        for (int k = 0; k < 40; k++)
            step(k % 3 == 0 ? 40 : 1234, 0, int'($urandom_range(0, 4095)),
                 1'($urandom), 1'($urandom), 1'($urandom), "R10 idle");

        // R7 R8: free component bits to visit every chooser transition and saturation
        for (int k = 0; k < 3000; k++)
            step(int'($urandom_range(0, 7)) * 131, 1'($urandom_range(0, 3) != 0),
                 int'($urandom_range(0, 7)) * 131, 1'($urandom), 1'($urandom), 1'($urandom),
                 "R7 R8 random");

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule